// File: doc/BRIEF.md
# FP/Integer Register Move Unit

This block executes one instruction class: a raw bit copy between a 32-entry, 64-bit general-purpose register file and a 32-entry, 128-bit vector register file. No value is converted. The unit decodes a 32-bit instruction word and checks the pairing of integer width and floating-point width. It then copies a half, single or double slice in one of two directions. The slice goes either to or from the low lane of a vector register, or to or from its upper 64-bit lane. Narrow results are zero-extended. An encoding that belongs to this class but breaks the width rules raises a one-cycle undefined flag and changes no state. A word that does not belong to the class is ignored without any flag.

A move is requested by holding `valid_i` high for one clock with the word on `instr_i`, and its result is visible on the read ports after that clock edge. Each register file has one combinational read port for observation and one preload write port for seeding contents. Half-precision support is chosen by the `HALF_EN` parameter.

Top module: `fmv_unit`

## Requirements
- R1: After reset every general-purpose and vector register reads zero and `undef_o` is low.
- R2: With `valid_i` high, a word is taken as this instruction only when bits 30:24 are 0011110, bit 21 is 1, bit 20 is 0, bits 18:17 are 11 and bits 15:10 are zero. Any other word changes no register and leaves `undef_o` low.
- R3: Field positions are: bit 31 integer size (0 = 32, 1 = 64), bits 23:22 FP type (00 = 32, 01 = 64, 11 = 16, 10 = upper-lane 64), bit 19 lane select, bit 16 direction (1 = integer to FP, 0 = FP to integer), bits 9:5 source, bits 4:0 destination. With bit 19 = 0, the word is legal only when the FP width is 16 or equals the integer width.
- R4: With bit 19 = 1, the move uses bits 127:64 of the vector register, and it is legal only with bit 31 = 1 and type 10. Type 10 with bit 19 = 0 is undefined.
- R5: When `HALF_EN` is 0, every type-11 word is undefined.
- R6: FP to integer takes the FP-width slice of the selected lane of the source vector register, zero-extends it to 64 bits and writes it to the destination general-purpose register, so a 32-bit integer write clears bits 63:32.
- R7: Integer to FP into lane 0 writes the low FP-width bits of the source general-purpose register and clears every higher bit of the destination vector register.
- R8: Integer to FP into the upper lane writes bits 127:64 with the source value and leaves bits 63:0 unchanged.
- R9: An undefined word raises `undef_o` for exactly the cycle after the strobe and changes no register.
- R10: With `valid_i` low, no move is performed whatever `instr_i` holds.
- R11: A move's result is visible on the read ports in the cycle after the clock edge that sampled the strobe.
- R12: A preload write of either file is visible after the next clock edge. A move writing the same file in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction strobe |
| instr_i | input | 32 | Instruction word |
| gpr_ld_en_i | input | 1 | General-purpose preload enable |
| gpr_ld_addr_i | input | 5 | General-purpose preload index |
| gpr_ld_data_i | input | 64 | General-purpose preload value |
| vec_ld_en_i | input | 1 | Vector preload enable |
| vec_ld_addr_i | input | 5 | Vector preload index |
| vec_ld_data_i | input | 128 | Vector preload value |
| gpr_rd_addr_i | input | 5 | General-purpose observation index |
| gpr_rd_data_o | output | 64 | General-purpose observation value |
| vec_rd_addr_i | input | 5 | Vector observation index |
| vec_rd_data_o | output | 128 | Vector observation value |
| undef_o | output | 1 | Undefined-encoding pulse |

## Verification
The register-file assertions assume that a write of a given index can only come from the merged write port, and that an idle cycle leaves the whole array stable. This in turn assumes that preload and move never both target one file in the same cycle unless the move wins. The bench keeps to this by seeding the files only during a separate preload phase. Words for the moves are built from individual fields, so every legal pairing, every illegal pairing and words with broken fixed bits reach the decoder in turn. A second instance with half precision disabled runs on the same inputs so that the feature gate is exercised.

// File: rtl/fmv_pkg.sv
package fmv_pkg;

    typedef enum logic [1:0] {
        FSZ_H = 2'd0,
        FSZ_S = 2'd1,
        FSZ_D = 2'd2
    } fsz_e;

    typedef struct packed {
        logic       hit;
        logic       legal;
        logic       to_fp;
        logic       int64;
        logic       upper;
        fsz_e       fsz;
        logic [4:0] rn;
        logic [4:0] rd;
    } fmv_dec_t;

    typedef struct packed {
        logic         gpr_we;
        logic [63:0]  gpr_wdata;
        logic         vec_we;
        logic [127:0] vec_wdata;
        logic         undef;
    } fmv_act_t;

endpackage

// File: rtl/fmv_regfile.sv
module fmv_regfile #(
    parameter int WIDTH = 64,
    parameter int DEPTH = 32,
    parameter int NRD   = 2,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  logic [WIDTH-1:0]          wdata,
    input  logic [NRD-1:0][AW-1:0]    raddr,
    output logic [NRD-1:0][WIDTH-1:0] rdata
);

    logic [DEPTH-1:0][WIDTH-1:0] mem_d;
    logic [DEPTH-1:0][WIDTH-1:0] mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem_q[raddr[p]];
    end

    // R11: a written value is held in the array after the edge
    assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem_q[$past(waddr)] == $past(wdata));

    // R10: with no write strobe the whole array keeps its contents
    assert_hold_without_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> mem_q == $past(mem_q));

endmodule

// File: rtl/fmv_decode.sv
module fmv_decode
    import fmv_pkg::*;
#(
    parameter bit HALF_EN = 1'b1
) (
    input  logic [31:0] instr,
    output fmv_dec_t    dec
);

    logic       sf;
    logic [1:0] ftype;
    logic       lane;

    always_comb begin
        sf    = instr[31];
        ftype = instr[23:22];
        lane  = instr[19];

        dec.hit = (instr[30:24] == 7'b0011110) && instr[21] && !instr[20]
                  && (instr[18:17] == 2'b11) && (instr[15:10] == 6'd0);

        if (lane) begin
            dec.legal = sf && (ftype == 2'b10);
        end else begin
            unique case (ftype)
                2'b00:   dec.legal = !sf;
                2'b01:   dec.legal = sf;
                2'b11:   dec.legal = HALF_EN;
                default: dec.legal = 1'b0;
            endcase
        end

        unique case (ftype)
            2'b11:   dec.fsz = FSZ_H;
            2'b00:   dec.fsz = FSZ_S;
            default: dec.fsz = FSZ_D;
        endcase

        dec.to_fp = instr[16];
        dec.int64 = sf;
        dec.upper = lane;
        dec.rn    = instr[9:5];
        dec.rd    = instr[4:0];
    end

    // R5: without half support no type-11 word is legal
    always_comb begin
        if (dec.hit && (ftype == 2'b11) && !HALF_EN) begin
            assert_half_gate_R5: assert (!dec.legal);
        end
    end

    // R4: an accepted upper-lane move is always the 64-bit, type-10 form
    always_comb begin
        if (dec.hit && dec.legal && dec.upper) begin
            assert_upper_form_R4: assert (sf && (ftype == 2'b10));
        end
    end

endmodule

// File: rtl/fmv_exec.sv
module fmv_exec
    import fmv_pkg::*;
(
    input  logic         valid,
    input  fmv_dec_t     dec,
    input  logic [63:0]  gpr_src,
    input  logic [127:0] vec_src,
    input  logic [127:0] vec_dst,
    output fmv_act_t     act
);

    logic [63:0] mask;
    logic [63:0] lane_val;
    logic [63:0] int_val;
    logic        go;

    always_comb begin
        unique case (dec.fsz)
            FSZ_H:   mask = 64'h0000_0000_0000_FFFF;
            FSZ_S:   mask = 64'h0000_0000_FFFF_FFFF;
            default: mask = '1;
        endcase

        go       = valid && dec.hit && dec.legal;
        lane_val = (dec.upper ? vec_src[127:64] : vec_src[63:0]) & mask;
        int_val  = gpr_src & mask;
        if (!dec.int64) begin
            lane_val[63:32] = 32'd0;
            int_val[63:32]  = 32'd0;
        end

        act.undef     = valid && dec.hit && !dec.legal;
        act.gpr_we    = go && !dec.to_fp;
        act.gpr_wdata = lane_val;
        act.vec_we    = go && dec.to_fp;
        if (dec.upper) begin
            act.vec_wdata = {int_val, vec_dst[63:0]};
        end else begin
            act.vec_wdata = {64'd0, int_val};
        end
    end

    // R6: a half-width read into the integer side carries no bits above 15
    always_comb begin
        if (act.gpr_we && (dec.fsz == FSZ_H)) begin
            assert_half_zero_ext_R6: assert (act.gpr_wdata[63:16] == 48'd0);
        end
    end

    // R7: a lane-0 vector write never sets the upper lane
    always_comb begin
        if (act.vec_we && !dec.upper) begin
            assert_lane0_clear_R7: assert (act.vec_wdata[127:64] == 64'd0);
        end
    end

endmodule

// File: rtl/fmv_unit.sv
module fmv_unit
    import fmv_pkg::*;
#(
    parameter bit HALF_EN = 1'b1,
    parameter int NREG    = 32,
    parameter int XLEN    = 64,
    parameter int VLEN    = 128,
    parameter int RAW     = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic [31:0]     instr_i,
    input  logic            gpr_ld_en_i,
    input  logic [RAW-1:0]  gpr_ld_addr_i,
    input  logic [XLEN-1:0] gpr_ld_data_i,
    input  logic            vec_ld_en_i,
    input  logic [RAW-1:0]  vec_ld_addr_i,
    input  logic [VLEN-1:0] vec_ld_data_i,
    input  logic [RAW-1:0]  gpr_rd_addr_i,
    output logic [XLEN-1:0] gpr_rd_data_o,
    input  logic [RAW-1:0]  vec_rd_addr_i,
    output logic [VLEN-1:0] vec_rd_data_o,
    output logic            undef_o
);

    typedef struct packed {
        logic undef;
    } top_state_t;

    top_state_t st_d;
    top_state_t st_q;

    fmv_dec_t dec;
    fmv_act_t act;

    logic [1:0][XLEN-1:0] gpr_rdata;
    logic [2:0][VLEN-1:0] vec_rdata;

    logic            gpr_we;
    logic [RAW-1:0]  gpr_waddr;
    logic [XLEN-1:0] gpr_wdata;
    logic            vec_we;
    logic [RAW-1:0]  vec_waddr;
    logic [VLEN-1:0] vec_wdata;

    fmv_decode #(.HALF_EN(HALF_EN)) u_dec (
        .instr (instr_i),
        .dec   (dec)
    );

    fmv_exec u_exec (
        .valid   (valid_i),
        .dec     (dec),
        .gpr_src (gpr_rdata[0]),
        .vec_src (vec_rdata[0]),
        .vec_dst (vec_rdata[1]),
        .act     (act)
    );

    always_comb begin
        st_d.undef = act.undef;

        gpr_we    = act.gpr_we || gpr_ld_en_i;
        gpr_waddr = act.gpr_we ? dec.rd : gpr_ld_addr_i;
        gpr_wdata = act.gpr_we ? act.gpr_wdata : gpr_ld_data_i;

        vec_we    = act.vec_we || vec_ld_en_i;
        vec_waddr = act.vec_we ? dec.rd : vec_ld_addr_i;
        vec_wdata = act.vec_we ? act.vec_wdata : vec_ld_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    fmv_regfile #(.WIDTH(XLEN), .DEPTH(NREG), .NRD(2)) u_gpr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (gpr_we),
        .waddr (gpr_waddr),
        .wdata (gpr_wdata),
        .raddr ({gpr_rd_addr_i, dec.rn}),
        .rdata (gpr_rdata)
    );

    fmv_regfile #(.WIDTH(VLEN), .DEPTH(NREG), .NRD(3)) u_vec (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (vec_we),
        .waddr (vec_waddr),
        .wdata (vec_wdata),
        .raddr ({vec_rd_addr_i, dec.rd, dec.rn}),
        .rdata (vec_rdata)
    );

    assign gpr_rd_data_o = gpr_rdata[1];
    assign vec_rd_data_o = vec_rdata[2];
    assign undef_o       = st_q.undef;

    // R9: the flag only ever follows a strobe one cycle earlier
    assert_undef_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> $past(valid_i));

    // R3: one word causes at most one of: integer write, vector write, flag
    assert_single_effect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act.gpr_we, act.vec_we, act.undef}));

    // R8: an upper-lane write keeps the low lane of its destination
    assert_upper_keeps_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (act.vec_we && dec.upper) |=> vec_rdata[1][63:0] == $past(vec_rdata[1][63:0]) ||
                                      $past(dec.rd) != dec.rd);

endmodule

// File: tb/sim_fmv_unit.sv
module sim_fmv_unit;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_i = 1'b0;
    logic [31:0]  instr_i = 32'd0;
    logic         gpr_ld_en_i = 1'b0;
    logic [4:0]   gpr_ld_addr_i = 5'd0;
    logic [63:0]  gpr_ld_data_i = 64'd0;
    logic         vec_ld_en_i = 1'b0;
    logic [4:0]   vec_ld_addr_i = 5'd0;
    logic [127:0] vec_ld_data_i = 128'd0;
    logic [4:0]   gpr_rd_addr_i = 5'd0;
    logic [4:0]   vec_rd_addr_i = 5'd0;
    logic [63:0]  gpr_rd_data_o;
    logic [127:0] vec_rd_data_o;
    logic         undef_o;
    logic [63:0]  nh_gpr;
    logic [127:0] nh_vec;
    logic         nh_undef;

    always #(CLK_PERIOD/2) clk = ~clk;

    fmv_unit u0 (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
        .gpr_ld_en_i(gpr_ld_en_i), .gpr_ld_addr_i(gpr_ld_addr_i), .gpr_ld_data_i(gpr_ld_data_i),
        .vec_ld_en_i(vec_ld_en_i), .vec_ld_addr_i(vec_ld_addr_i), .vec_ld_data_i(vec_ld_data_i),
        .gpr_rd_addr_i(gpr_rd_addr_i), .gpr_rd_data_o(gpr_rd_data_o),
        .vec_rd_addr_i(vec_rd_addr_i), .vec_rd_data_o(vec_rd_data_o),
        .undef_o(undef_o)
    );

    fmv_unit #(.HALF_EN(1'b0)) u_nohalf (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
        .gpr_ld_en_i(gpr_ld_en_i), .gpr_ld_addr_i(gpr_ld_addr_i), .gpr_ld_data_i(gpr_ld_data_i),
        .vec_ld_en_i(vec_ld_en_i), .vec_ld_addr_i(vec_ld_addr_i), .vec_ld_data_i(vec_ld_data_i),
        .gpr_rd_addr_i(gpr_rd_addr_i), .gpr_rd_data_o(nh_gpr),
        .vec_rd_addr_i(vec_rd_addr_i), .vec_rd_data_o(nh_vec),
        .undef_o(nh_undef)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [63:0]  gm [32];
    logic [127:0] vm [32];
    logic         exp_undef;
    logic         exp_undef_nh;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic sf, input logic [1:0] ft, input logic rm,
                                         input logic toi, input logic [4:0] rn, input logic [4:0] rd);
        return {sf, 7'b0011110, ft, 1'b1, 1'b0, rm, 2'b11, toi, 6'd0, rn, rd};
    endfunction

    function automatic bit model_hit(input logic [31:0] w);
        return (w[30:24] == 7'b0011110) && (w[21] == 1'b1) && (w[20] == 1'b0) &&
               (w[18:17] == 2'b11) && (w[15:10] == 6'd0);
    endfunction

    function automatic bit model_legal(input logic [31:0] w, input bit half_ok);
        int isz;
        int fsz;
        isz = w[31] ? 64 : 32;
        if (w[19]) return (isz == 64) && (w[23:22] == 2'b10);
        if (w[23:22] == 2'b10) return 0;
        if (w[23:22] == 2'b11) return half_ok;
        fsz = (w[23:22] == 2'b00) ? 32 : 64;
        return fsz == isz;
    endfunction

    function automatic logic [63:0] width_mask(input logic [1:0] ft);
        case (ft)
            2'b11:   return 64'hFFFF;
            2'b00:   return 64'hFFFF_FFFF;
            default: return {64{1'b1}};
        endcase
    endfunction

    // model the effect of a strobed word
    task automatic model_apply(input logic [31:0] w);
        logic [63:0] v;
        int n;
        int d;
        n = int'(w[9:5]);
        d = int'(w[4:0]);
        exp_undef    = model_hit(w) && !model_legal(w, 1);
        exp_undef_nh = model_hit(w) && !model_legal(w, 0);
        if (model_hit(w) && model_legal(w, 1)) begin
            if (w[16]) begin
                v = gm[n] & width_mask(w[23:22]);
                if (w[19]) vm[d][127:64] = v;
                else       vm[d] = {64'd0, v};
            end else begin
                v = (w[19] ? vm[n][127:64] : vm[n][63:0]) & width_mask(w[23:22]);
                gm[d] = v;
            end
        end
    endtask

    task automatic observe(input string tag, input int d);
        gpr_rd_addr_i = d[4:0];
        vec_rd_addr_i = d[4:0];
        #1;
        chk({tag, " gpr"}, {64'd0, gpr_rd_data_o}, {64'd0, gm[d]});
        chk({tag, " vec"}, vec_rd_data_o, vm[d]);
    endtask

    task automatic step(input string tag, input logic [31:0] w, input logic v);
        @(negedge clk);
        valid_i = v;
        instr_i = w;
        if (v) model_apply(w);
        else begin exp_undef = 0; exp_undef_nh = 0; end
        @(posedge clk);
        @(negedge clk);
        valid_i = 1'b0;
        chk({tag, " undef"}, {127'd0, undef_o}, {127'd0, exp_undef});
        chk({tag, " nohalf undef R5"}, {127'd0, nh_undef}, {127'd0, exp_undef_nh});
        observe(tag, int'(w[4:0]));
        observe(tag, int'(w[9:5]));
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 32; i++) observe(tag, i);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            gm[i] = '0;
            vm[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 undef after reset", {127'd0, undef_o}, 128'd0);
        sweep("R1 reset contents");

        // R12: seed both files
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            gpr_ld_en_i   = 1'b1;
            gpr_ld_addr_i = i[4:0];
            gpr_ld_data_i = 64'hF0E1_D2C3_B4A5_9687 ^ (64'(i) * 64'h0101_0101_0101_0101);
            vec_ld_en_i   = 1'b1;
            vec_ld_addr_i = i[4:0];
            vec_ld_data_i = {64'h8899_AABB_CCDD_EEFF + 64'(i), 64'h1122_3344_5566_7788 ^ 64'(i << 8)};
            gm[i] = gpr_ld_data_i;
            vm[i] = vec_ld_data_i;
        end
        @(negedge clk);
        gpr_ld_en_i = 1'b0;
        vec_ld_en_i = 1'b0;
        sweep("R12 preload");

        // R6 / R11 FP to integer
        step("R6 single to W",       enc(0, 2'b00, 0, 0, 5'd3,  5'd10), 1);
        step("R6 half to X",         enc(1, 2'b11, 0, 0, 5'd4,  5'd11), 1);
        step("R6 half to W",         enc(0, 2'b11, 0, 0, 5'd5,  5'd12), 1);
        step("R11 double to X",      enc(1, 2'b01, 0, 0, 5'd6,  5'd13), 1);
        step("R4 upper lane to X",   enc(1, 2'b10, 1, 0, 5'd7,  5'd14), 1);
        // R7 / R8 integer to FP
        step("R7 W to single",       enc(0, 2'b00, 0, 1, 5'd20, 5'd1), 1);
        step("R7 X to half",         enc(1, 2'b11, 0, 1, 5'd21, 5'd2), 1);
        step("R7 W to half",         enc(0, 2'b11, 0, 1, 5'd22, 5'd8), 1);
        step("R7 X to double",       enc(1, 2'b01, 0, 1, 5'd23, 5'd9), 1);
        step("R8 X to upper lane",   enc(1, 2'b10, 1, 1, 5'd24, 5'd15), 1);
        step("R8 same reg both dir", enc(1, 2'b10, 1, 1, 5'd25, 5'd25), 1);
        // R3 / R4 / R9 undefined pairings
        step("R3 W with double",     enc(0, 2'b01, 0, 0, 5'd1,  5'd16), 1);
        step("R3 X with single",     enc(1, 2'b00, 0, 1, 5'd1,  5'd16), 1);
        step("R4 type10 lane0",      enc(1, 2'b10, 0, 1, 5'd1,  5'd17), 1);
        step("R4 upper with W",      enc(0, 2'b10, 1, 0, 5'd1,  5'd18), 1);
        step("R4 upper with double", enc(1, 2'b01, 1, 1, 5'd1,  5'd19), 1);
        step("R9 back to back",      enc(1, 2'b00, 0, 0, 5'd2,  5'd19), 1);
        sweep("R9 no state change");
        // R2 not this instruction
        step("R2 fixed bit broken",  enc(1, 2'b01, 0, 0, 5'd2, 5'd26) ^ 32'h0100_0000, 1);
        step("R2 other opcode",      enc(1, 2'b01, 0, 0, 5'd2, 5'd26) & ~32'h0002_0000, 1);
        step("R2 bits 15:10 set",    enc(0, 2'b00, 0, 1, 5'd2, 5'd26) | 32'h0000_0400, 1);
        step("R2 rmode high bit",    enc(1, 2'b10, 1, 0, 5'd2, 5'd26) | 32'h0010_0000, 1);
        // R10 no strobe
        step("R10 valid low",        enc(1, 2'b01, 0, 0, 5'd3, 5'd27), 0);
        // R12 move wins over preload on the same file
        @(negedge clk);
        valid_i = 1'b1;
        instr_i = enc(1, 2'b01, 0, 0, 5'd3, 5'd28);
        gpr_ld_en_i = 1'b1;
        gpr_ld_addr_i = 5'd29;
        gpr_ld_data_i = 64'hDEAD_BEEF_0000_0001;
        model_apply(instr_i);
        @(posedge clk);
        @(negedge clk);
        valid_i = 1'b0;
        gpr_ld_en_i = 1'b0;
        observe("R12 move priority", 28);
        observe("R12 load dropped", 29);
        sweep("final state");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog R11 actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule